// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor that renames part of its register set on every procedure call. Software sees 32 registers at any time, in four groups of eight: globals, outs, locals and ins. The out and local groups belong to the current window. The in group is not separate storage: it is the out group of the previous window. When a call shifts the window forward, values the caller placed in its outs become the callee's ins without any copying. The callee also gets a new, private set of locals and outs.

The block keeps eight physical windows in a ring. It tracks a current window pointer and a count of windows that hold live data. A shift forward (save) or backward (restore) that would run past the resident windows does not move the pointer. Instead it raises an overflow or underflow trap for one cycle. Trap software then stores old windows to memory or loads them back. It reports each finished spill or fill through a separate input, which adjusts the resident count without moving the pointer. There are two combinational read ports and one write port, all addressed by the 5-bit architectural register number.

Top module: `winreg_file`

## Requirements
- R1: After reset the window pointer is 0, the resident count is 1 and both trap outputs are low.
- R2: The register number encodes its group in bits [4:3]: 0 is global, 1 is out, 2 is local and 3 is in. Bits [2:0] select one of eight registers in the group. Both read ports return the addressed value in the same cycle and are independent of each other.
- R3: Global register 0 always reads as zero, and writes to it have no effect.
- R4: Globals 1 to 7 are shared by all windows and are not changed by save or restore.
- R5: An accepted save advances the pointer by one, modulo 8, and raises the resident count by one. In the new window, in register k shows the value the caller left in out register k, for k = 0 to 7 (so out 7 becomes in 7).
- R6: The locals and outs of a new window are separate storage from the caller's. After a restore, the caller's locals and outs hold the values they had before the save, except where the callee wrote its ins.
- R7: An accepted restore moves the pointer back by one, modulo 8, and lowers the resident count by one. A value the callee wrote to in register k is seen by the caller as out register k.
- R8: A save while the resident count is 7 raises the overflow trap for exactly the next cycle. The pointer and the count do not change.
- R9: A restore while the resident count is 1 raises the underflow trap for exactly the next cycle. The pointer and the count do not change.
- R10: Spill-done lowers the resident count by one, and never below 1. Fill-done raises it by one, and never above 7. Neither moves the pointer. Both asserted together have no effect. Both are ignored in a cycle that has a save or restore.
- R11: A write issued in the same cycle as a save or restore lands in the window that was current before the shift.
- R12: If save and restore are requested in the same cycle, the save is performed and the restore is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write register number |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Shift window forward |
| restore_req | input | 1 | Shift window back |
| spill_done | input | 1 | Trap software stored one window to memory |
| fill_done | input | 1 | Trap software loaded one window from memory |
| cwp | output | 3 | Current window pointer |
| resident | output | 4 | Number of windows holding live data |
| overflow_trap | output | 1 | One-cycle pulse: save refused |
| underflow_trap | output | 1 | One-cycle pulse: restore refused |

## Verification
A register write and a window shift can fall in the same cycle. The bench provokes this by writing a local register together with a save. It then writes a different value to the same local number in the new window and restores. It judges the result by reading the local back in the original window, where the first value must be found. The bench also drives save with restore, and spill or fill with a save, in one cycle. It compares the pointer and resident count with the priority the requirements give.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

   localparam int unsigned REGS_PER_GRP = 8;
   localparam int unsigned ARCH_AW      = 5;

   typedef enum logic [1:0] {
      GRP_GLB = 2'd0,
      GRP_OUT = 2'd1,
      GRP_LOC = 2'd2,
      GRP_IN  = 2'd3
   } reg_grp_e;

   function automatic reg_grp_e grp_of(input logic [ARCH_AW-1:0] a);
      return reg_grp_e'(a[ARCH_AW-1:ARCH_AW-2]);
   endfunction

endpackage

// File: rtl/winreg_addr_map.sv
module winreg_addr_map
   import winreg_pkg::*;
#(
   parameter int unsigned NWIN  = 8,
   parameter int unsigned CWP_W = $clog2(NWIN),
   parameter int unsigned PHYS  = REGS_PER_GRP + NWIN * 2 * REGS_PER_GRP,
   parameter int unsigned IDX_W = $clog2(PHYS)
) (
   input  logic [ARCH_AW-1:0] arch_addr,
   input  logic [CWP_W-1:0]   win,
   output logic [IDX_W-1:0]   phys_idx
);

   localparam int unsigned WIN_SZ = 2 * REGS_PER_GRP;

   logic [CWP_W-1:0] prev_win;
   logic [2:0]       sel;
   int unsigned      idx_i;

   assign prev_win = win - CWP_W'(1);
   assign sel      = arch_addr[2:0];

   always_comb begin
      unique case (grp_of(arch_addr))
         GRP_GLB: idx_i = int'(sel);
         GRP_OUT: idx_i = REGS_PER_GRP + int'(win) * WIN_SZ + int'(sel);
         GRP_LOC: idx_i = REGS_PER_GRP + int'(win) * WIN_SZ + REGS_PER_GRP + int'(sel);
         default: idx_i = REGS_PER_GRP + int'(prev_win) * WIN_SZ + int'(sel);
      endcase
      phys_idx = IDX_W'(idx_i);
   end

   // R2
   always_comb begin
      idx_range_chk: assert (idx_i < PHYS);
   end

endmodule

// File: rtl/winreg_storage.sv
module winreg_storage #(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned PHYS          = 136,
   parameter int unsigned IDX_W         = $clog2(PHYS),
   parameter bit          RESET_STORAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_idx,
   input  logic [DATA_W-1:0] w_data,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data
);

   logic [DATA_W-1:0] mem [PHYS];
   logic              we_live;

   assign we_live = we && (w_idx != '0);

   generate
      if (RESET_STORAGE) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(PHYS); i++) mem[i] <= '0;
            end else if (we_live) begin
               mem[w_idx] <= w_data;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we_live) mem[w_idx] <= w_data;
         end
      end
   endgenerate

   assign ra_data = (ra_idx == '0) ? '0 : mem[ra_idx];
   assign rb_data = (rb_idx == '0) ? '0 : mem[rb_idx];

endmodule

// File: rtl/winreg_window_ctl.sv
module winreg_window_ctl #(
   parameter int unsigned NWIN  = 8,
   parameter int unsigned CWP_W = $clog2(NWIN),
   parameter int unsigned RES_W = CWP_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             save_req,
   input  logic             restore_req,
   input  logic             spill_done,
   input  logic             fill_done,
   output logic [CWP_W-1:0] cwp_q,
   output logic [RES_W-1:0] res_q,
   output logic             ovf_q,
   output logic             unf_q
);

   localparam logic [RES_W-1:0] MAXRES = RES_W'(NWIN - 1);
   localparam logic [RES_W-1:0] ONE    = RES_W'(1);

   logic full, empty;
   assign full  = (res_q == MAXRES);
   assign empty = (res_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_q <= '0;
         res_q <= ONE;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
         if (save_req) begin
            if (full) ovf_q <= 1'b1;
            else begin
               cwp_q <= cwp_q + CWP_W'(1);
               res_q <= res_q + ONE;
            end
         end else if (restore_req) begin
            if (empty) unf_q <= 1'b1;
            else begin
               cwp_q <= cwp_q - CWP_W'(1);
               res_q <= res_q - ONE;
            end
         end else if (spill_done && !fill_done) begin
            if (!empty) res_q <= res_q - ONE;
         end else if (fill_done && !spill_done) begin
            if (!full) res_q <= res_q + ONE;
         end
      end
   end

   // R10
   res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_q >= ONE) && (res_q <= MAXRES));

   // R5
   save_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && !full) |=> (cwp_q == $past(cwp_q) + CWP_W'(1)));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_req && full) |=> (ovf_q && $stable(cwp_q) && $stable(res_q)));

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_req && !save_req && empty) |=> (unf_q && $stable(cwp_q) && $stable(res_q)));

endmodule

// File: rtl/winreg_file.sv
module winreg_file
   import winreg_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned NWIN          = 8,
   parameter bit          RESET_STORAGE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [4:0]                 rd_a_addr,
   output logic [DATA_W-1:0]          rd_a_data,
   input  logic [4:0]                 rd_b_addr,
   output logic [DATA_W-1:0]          rd_b_data,
   input  logic                       wr_en,
   input  logic [4:0]                 wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       save_req,
   input  logic                       restore_req,
   input  logic                       spill_done,
   input  logic                       fill_done,
   output logic [$clog2(NWIN)-1:0]    cwp,
   output logic [$clog2(NWIN):0]      resident,
   output logic                       overflow_trap,
   output logic                       underflow_trap
);

   localparam int unsigned CWP_W = $clog2(NWIN);
   localparam int unsigned RES_W = CWP_W + 1;
   localparam int unsigned PHYS  = REGS_PER_GRP + NWIN * 2 * REGS_PER_GRP;
   localparam int unsigned IDX_W = $clog2(PHYS);

   generate
      if (NWIN < 3 || (1 << CWP_W) != NWIN) begin : g_bad_nwin
         $error("NWIN must be a power of two of at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0] ra_idx, rb_idx, w_idx;

   winreg_addr_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS(PHYS), .IDX_W(IDX_W)) u_map_a (
      .arch_addr(rd_a_addr), .win(cwp), .phys_idx(ra_idx));
   winreg_addr_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS(PHYS), .IDX_W(IDX_W)) u_map_b (
      .arch_addr(rd_b_addr), .win(cwp), .phys_idx(rb_idx));
   winreg_addr_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PHYS(PHYS), .IDX_W(IDX_W)) u_map_w (
      .arch_addr(wr_addr), .win(cwp), .phys_idx(w_idx));

   winreg_storage #(.DATA_W(DATA_W), .PHYS(PHYS), .IDX_W(IDX_W),
                    .RESET_STORAGE(RESET_STORAGE)) u_store (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .w_idx(w_idx), .w_data(wr_data),
      .ra_idx(ra_idx), .ra_data(rd_a_data), .rb_idx(rb_idx), .rb_data(rd_b_data));

   winreg_window_ctl #(.NWIN(NWIN), .CWP_W(CWP_W), .RES_W(RES_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
      .spill_done(spill_done), .fill_done(fill_done),
      .cwp_q(cwp), .res_q(resident), .ovf_q(overflow_trap), .unf_q(underflow_trap));

   // R8
   trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({overflow_trap, underflow_trap}));

   // R4
   glob_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && rd_a_addr[4:3] == 2'b00) |=>
         ((rd_a_addr != $past(rd_a_addr)) || (rd_a_data == $past(rd_a_data))));

endmodule

// File: tb/winreg_file_tb.sv
module winreg_file_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
   logic [31:0] rd_a_data, rd_b_data, wr_data;
   logic        wr_en, save_req, restore_req, spill_done, fill_done;
   logic [2:0]  cwp;
   logic [3:0]  resident;
   logic        overflow_trap, underflow_trap;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   winreg_file u_dut (
      .clk(clk), .rst_n(rst_n),
      .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
      .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .save_req(save_req), .restore_req(restore_req),
      .spill_done(spill_done), .fill_done(fill_done),
      .cwp(cwp), .resident(resident),
      .overflow_trap(overflow_trap), .underflow_trap(underflow_trap));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      wr_en = 0; save_req = 0; restore_req = 0; spill_done = 0; fill_done = 0;
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      tick();
   endtask

   function automatic logic [31:0] out_pat(input int d, input int r);
      return 32'hA000 + 32'(d * 16 + r);
   endfunction
   function automatic logic [31:0] loc_pat(input int d, input int r);
      return 32'hB000 + 32'(d * 16 + r);
   endfunction

   task automatic rd_a(input logic [4:0] a, output logic [31:0] d);
      rd_a_addr = a; #1; d = rd_a_data;
   endtask
   task automatic rd_b(input logic [4:0] a, output logic [31:0] d);
      rd_b_addr = a; #1; d = rd_b_data;
   endtask

   task automatic chk_state(input string tag, input int c, input int r);
      check({tag, " cwp"}, 32'(cwp), 32'(c));
      check({tag, " resident"}, 32'(resident), 32'(r));
   endtask

   task automatic chk_globals(input string tag);
      logic [31:0] v;
      for (int g = 1; g < 8; g++) begin
         rd_a(5'(g), v);
         check(tag, v, 32'h6000 + 32'(g));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, w;
      rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_a_addr = 0; rd_b_addr = 0;
      save_req = 0; restore_req = 0; spill_done = 0; fill_done = 0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;

      // R1 reset state
      chk_state("R1", 0, 1);
      check("R1 ovf", 32'(overflow_trap), 0);
      check("R1 unf", 32'(underflow_trap), 0);

      // R3 and R2: globals
      for (int g = 1; g < 8; g++) wr(5'(g), 32'h6000 + 32'(g));
      wr(5'd0, 32'hDEAD_BEEF);
      rd_a(5'd0, v); check("R3 g0 port a", v, 0);
      rd_b(5'd0, v); check("R3 g0 port b", v, 0);
      chk_globals("R2 globals");

      // walk forward: R2, R5
      for (int d = 0; d < 7; d++) begin
         for (int r = 0; r < 8; r++) begin
            wr(5'(8 + r), out_pat(d, r));
            wr(5'(16 + r), loc_pat(d, r));
         end
         for (int r = 0; r < 8; r++) begin
            rd_a(5'(8 + r), v);  rd_b(5'(16 + r), w);
            check("R2 out read", v, out_pat(d, r));
            check("R2 local read", w, loc_pat(d, r));
         end
         if (d < 6) begin
            save_req = 1; tick();
            chk_state("R5 save", d + 1, d + 2);
            for (int r = 0; r < 8; r++) begin
               rd_a(5'(24 + r), v);
               check("R5 ins alias caller outs", v, out_pat(d, r));
            end
         end
      end

      // R8 overflow
      save_req = 1; tick();
      check("R8 ovf pulse", 32'(overflow_trap), 1);
      chk_state("R8 no move", 6, 7);
      tick();
      check("R8 ovf one cycle", 32'(overflow_trap), 0);
      chk_globals("R4 globals after saves");

      // walk back: R6, R7
      for (int d = 6; d >= 1; d--) begin
         wr(5'd27, 32'hC000 + 32'(d));
         restore_req = 1; tick();
         chk_state("R7 restore", d - 1, d);
         rd_a(5'd11, v); check("R7 callee in3 -> caller out3", v, 32'hC000 + 32'(d));
         for (int r = 0; r < 8; r++) begin
            rd_a(5'(16 + r), v); check("R6 caller locals kept", v, loc_pat(d - 1, r));
            if (r != 3) begin
               rd_b(5'(8 + r), w); check("R6 caller outs kept", w, out_pat(d - 1, r));
            end
         end
      end

      // R9 underflow
      restore_req = 1; tick();
      check("R9 unf pulse", 32'(underflow_trap), 1);
      chk_state("R9 no move", 0, 1);
      tick();
      check("R9 unf one cycle", 32'(underflow_trap), 0);
      chk_globals("R4 globals after restores");

      // R11 write together with save
      wr_en = 1; wr_addr = 5'd21; wr_data = 32'h1111; save_req = 1; tick();
      chk_state("R11 save taken", 1, 2);
      wr(5'd21, 32'h2222);
      rd_a(5'd21, v); check("R11 new window local", v, 32'h2222);
      restore_req = 1; tick();
      rd_a(5'd21, v); check("R11 write in old window", v, 32'h1111);

      // R10 spill / fill
      fill_done = 1; tick(); chk_state("R10 fill", 0, 2);
      fill_done = 1; tick(); chk_state("R10 fill", 0, 3);
      fill_done = 1; spill_done = 1; tick(); chk_state("R10 both", 0, 3);
      spill_done = 1; tick(); chk_state("R10 spill", 0, 2);
      spill_done = 1; tick(); chk_state("R10 spill", 0, 1);
      spill_done = 1; tick(); chk_state("R10 spill floor", 0, 1);
      spill_done = 1; save_req = 1; tick(); chk_state("R10 spill ignored with save", 1, 2);
      fill_done = 1; restore_req = 1; tick(); chk_state("R10 fill ignored with restore", 0, 1);
      for (int k = 0; k < 8; k++) begin
         fill_done = 1; tick();
      end
      chk_state("R10 fill ceiling", 0, 7);
      for (int k = 0; k < 6; k++) begin
         spill_done = 1; tick();
      end
      chk_state("R10 back to one", 0, 1);

      // R12 save wins over restore
      save_req = 1; restore_req = 1; tick();
      chk_state("R12 save wins", 1, 2);
      restore_req = 1; tick();
      chk_state("R12 back", 0, 1);

      // R5 pointer wrap with spills keeping room
      wr(5'd15, 32'h7777);
      for (int k = 1; k <= 9; k++) begin
         save_req = 1; tick();
         spill_done = 1; tick();
         chk_state("R5 wrap", k % 8, 1);
         if (k == 1) begin
            rd_a(5'd31, v); check("R5 out7 becomes in7", v, 32'h7777);
         end
      end
      chk_globals("R4 globals after wrap");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule